// File: doc/BRIEF.md
# Tree and Shift-Register Deserializer

The block turns one serial bit stream into 10-bit parallel words, working entirely from a clock at half the bit rate. A front tree stage samples the serial input on both edges of that clock. This splits the stream into an even lane and an odd lane, each running at half the bit rate.

Each lane then feeds a short shift register that advances once per half-rate cycle. A free-running divide-by-5 counter raises a load pulse for one cycle out of every five. That pulse copies the ten collected bits into the output word register, interleaved back into arrival order. The registered pulse, one cycle later, is the word-valid strobe and marks the word rate: one tenth of the serial bit rate.

The block is used behind a receiver that already delivers clean single-ended data with a matching half-rate clock. Word alignment is left to logic downstream.

Top module: `deser_tree_shift`

## Requirements
- R1: A new word is produced every 5 half-rate cycles, so one word per 10 serial bits. word_valid_o rises in the cycle that follows the edge at which the word register loads.
- R2: Within a word, bit i is the i-th bit of its 10-bit group in arrival order: bit 0 is the earliest bit and bit 9 the latest.
- R3: Bits sampled on the rising edge of clk_i land on the even word positions (0, 2, 4, 6, 8). Bits sampled on the falling edge land on the odd positions (1, 3, 5, 7, 9).
- R4: word_valid_o is high for exactly one half-rate cycle and then low for four, repeating (a 1:4 duty cycle).
- R5: While rst_ni is low, word_o reads 0 and word_valid_o reads 0, with no clock edge needed. The counter and both lanes are also cleared.
- R6: After reset is released just after a rising edge, word_valid_o first goes high just after the fifth rising edge. Word 1 takes in the rising-edge bit that was due at the release edge as 0, because the even sampler was still in reset then.
- R7: word_o holds its value between word_valid_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-rate clock; both edges sample the serial input |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_i | input | 1 | Serial data, two bits per clk_i period |
| word_o | output | 10 | Parallel word, bit 0 earliest |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The assertions check, on every cycle, the behaviour that follows from one cycle to the next. They cover the lane shift, the counter wrap, the single-cycle pulse, the strobe following the load and the word holding between loads. Only the bench scenarios can show the full ordering of bits across a word and the even and odd placement. They are also the only place to see the exact first-word timing after reset and the correct content under zero, one, alternating, sparse-one and scrambled streams.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int unsigned LANES = 2;  // 1:2 tree front end
endpackage

// File: rtl/tree_split.sv
module tree_split (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_i,
  output logic even_o,
  output logic odd_o
);
  logic even_q, odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) even_q <= 1'b0;
    else         even_q <= ser_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) odd_q <= 1'b0;
    else         odd_q <= ser_i;
  end

  assign even_o = even_q;
  assign odd_o  = odd_q;
endmodule

// File: rtl/lane_shift.sv
module lane_shift #(
  parameter int unsigned DEPTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  output logic [DEPTH-1:0] nxt_o
);
  // The tree flop feeding bit_i is the first stage; DEPTH-1 stages live here.
  logic [DEPTH-2:0] sr_q;

  assign nxt_o = {bit_i, sr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= nxt_o[DEPTH-1:1];
  end

  AST_LANE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_q[DEPTH-2] == $past(bit_i)); // R2

  if (DEPTH > 2) begin : g_deep
    AST_LANE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sr_q[DEPTH-3:0] == $past(sr_q[DEPTH-2:1])); // R2
  end
endmodule

// File: rtl/div_pulse.sv
module div_pulse #(
  parameter int unsigned DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pulse_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = (cnt_q == LAST);

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (cnt_q == '0)); // R1
  AST_PULSE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R4
endmodule

// File: rtl/deser_tree_shift.sv
module deser_tree_shift
  import deser_pkg::*;
#(
  parameter int unsigned LANE_DEPTH = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ser_i,
  output logic [LANES*LANE_DEPTH-1:0] word_o,
  output logic                        word_valid_o
);
  localparam int unsigned WORD_W = LANES * LANE_DEPTH;

  logic                  lane_in  [LANES];
  logic [LANE_DEPTH-1:0] lane_nxt [LANES];
  logic [WORD_W-1:0]     word_d, word_q;
  logic                  load, valid_q;

  tree_split u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ser_i  (ser_i),
    .even_o (lane_in[0]),
    .odd_o  (lane_in[1])
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_shift #(.DEPTH(LANE_DEPTH)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bit_i  (lane_in[l]),
      .nxt_o  (lane_nxt[l])
    );
    for (genvar j = 0; j < LANE_DEPTH; j++) begin : g_pos
      assign word_d[j*LANES + l] = lane_nxt[l][j];
    end
  end

  div_pulse #(.DIV(LANE_DEPTH)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_o (load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) word_q <= word_d;
    end
  end

  assign word_o       = word_q;
  assign word_valid_o = valid_q;

  AST_VALID_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(load)); // R1
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o); // R4
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(word_q)); // R7
endmodule

// File: tb/sim_deser_tree_shift.sv
`timescale 1ns/1ps
module sim_deser_tree_shift;
  localparam int WORDS = 12;
  localparam int NB    = 10*WORDS + 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser = 1'b0;
  logic [9:0] word;
  logic       valid;

  int checks = 0;
  int fails  = 0;
  logic b [NB];

  always #2.5 clk = ~clk;

  deser_tree_shift u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ser_i        (ser),
    .word_o       (word),
    .word_valid_o (valid)
  );

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic pat_bit(input int p, input int idx);
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return idx[0];
      3: return (idx % 11) == 3;
      default: return ((idx*idx + 7*idx + (idx >> 3)) >> 2) & 1;
    endcase
  endfunction

  task automatic run(input int p, input string tag);
    logic [9:0] exp_word;
    for (int i = 0; i < NB; i++) b[i] = pat_bit(p, i);
    b[0] = 1'b0;  // even sample at release edge is still in reset (R6)
    @(posedge clk); #1;
    rst_n = 1'b0;
    ser = 1'b1;
    #0.5;
    chk("R5 word in reset", word, 10'h000);
    chk("R5 valid in reset", {9'b0, valid}, 10'h000);
    repeat (2) @(posedge clk);
    #1;
    chk("R5 word held in reset", word, 10'h000);
    rst_n = 1'b1;
    ser = b[1];
    exp_word = 10'h000;
    for (int k = 1; k <= 5*WORDS + 1; k++) begin
      @(negedge clk); #1;
      ser = b[2*k];
      @(posedge clk); #1;
      ser = b[2*k+1];
      chk("R4 R6 valid timing", {9'b0, valid}, {9'b0, (k % 5) == 0});
      if ((k % 5) == 0) begin
        for (int i = 0; i < 10; i++) exp_word[i] = b[10*(k/5 - 1) + i];
        chk(tag, word, exp_word);
      end else begin
        chk("R7 word hold", word, exp_word);
      end
    end
  endtask

  initial begin
    run(0, "R1 zeros");
    run(1, "R2 ones");
    run(2, "R3 alternating");
    run(3, "R2 sparse one");
    run(4, "R1 R2 scrambled");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule